// File: doc/BRIEF.md
# Frame-Qualified Pixel Clock Selector

This block chooses the clock that feeds a downstream pixel-clock pin. Out of reset it forwards a free-running reference clock, so a serial link and its control channel can operate while an attached camera is still being configured. The camera's own pixel clock is not trusted until the camera's internal PLL has had time to lock. That period is measured in frames, not in clock cycles.

A qualifier brings the camera's vertical-sync line into the reference domain and counts its rising edges. One frame lasts well over a hundred thousand pixel clocks, so a handful of frame pulses covers the PLL settling time with a very small counter. When the programmed count is reached, a break-before-make 2:1 clock multiplexer hands the output over to the camera pixel clock divided by two. The choice then stays fixed until the next reset. A status output reports which source drives the output.

Top module: `vsync_clk_switch`

## Requirements
- R1: While the reference is selected and settled (from four reference cycles after reset release), `clk_out` equals `ref_clk`: high just after each rising edge and low just after each falling edge.
- R2: When the camera source is selected, `clk_out` has a period of exactly twice the `cam_pclk` period.
- R3: Only rising edges of `vsync` are counted. A pulse held high for many cycles counts once.
- R4: The output never switches to the camera source before `NUM_VSYNC` (default 4) rising edges of `vsync` have occurred since reset.
- R5: After the `NUM_VSYNC`-th rising edge, `sel_cam` becomes 1 within 40 reference cycles.
- R6: Once the camera source is selected, it stays selected until `rst_n` is driven low, whatever `vsync` does afterwards.
- R7: The two source enables are never on together. `clk_out` never produces a high or low phase shorter than half a reference period.
- R8: `sel_cam` is 0 during reset and while the reference drives the output. It is 1 only when the camera enable is on and the reference enable is off. Encoding: 0 = reference, 1 = camera.
- R9: A reset in the middle of the count discards the edges already seen. `NUM_VSYNC` fresh edges are then needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; clocks the qualifier and the status output |
| rst_n | input | 1 | Synchronous active-low reset, sampled in the reference domain and resynchronised into the camera domain |
| cam_pclk | input | 1 | Camera pixel clock |
| vsync | input | 1 | Camera vertical-sync, asynchronous to `ref_clk` |
| clk_out | output | 1 | Selected output clock |
| sel_cam | output | 1 | Selected source: 0 = reference, 1 = camera pixel clock / 2 |

## Verification
The checker evaluates these properties on every reference cycle:
- The two enables are mutually exclusive.
- The switch request is sticky.
- No request appears before the programmed number of synchronised sync edges.
- The status bit agrees with the enables.
- The status bit clears under reset.
- The hand-over completes inside a bounded window.

Three things can only be shown by the bench's scenarios, which compare every cycle against a behavioural model:
- the waveform of the output clock itself (tracking the reference, then the divided period);
- the absence of runt pulses across the hand-over;
- the effect of a long sync pulse and of a reset in the middle of the count.

// File: rtl/clk_sw_pkg.sv
// Shared definitions for the frame-qualified clock selector.
// Assumes nothing beyond standard SystemVerilog.
package clk_sw_pkg;

    // Encoding of the selected source as seen on the status output.
    typedef enum logic {
        SRC_REF = 1'b0,
        SRC_CAM = 1'b1
    } clk_src_e;

    // Width needed to hold a count from 0 up to and including max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/clk_sync_bits.sv
// Multi-stage flip-flop synchroniser for a single level signal.
// Assumes d is a quasi-static level; reset is synchronous, active-low,
// and loads RST_VAL into every stage.
module clk_sync_bits #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] stage_q;

    generate
        for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift the level one stage further into the destination domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[gi] <= RST_VAL;
                end else begin
                    if (gi == 0) begin
                        stage_q[gi] <= d;
                    end else begin
                        stage_q[gi] <= stage_q[(gi == 0) ? 0 : gi-1];
                    end
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pclk_div2.sv
// Divide-by-two of the camera pixel clock plus the camera-domain reset.
// Assumes cam_pclk toggles while rst_n is low so that the reset reaches
// the divider; the reset is resynchronised and applied synchronously.
module pclk_div2 #(
    parameter int SYNC_STAGES = 2
) (
    input  logic cam_pclk,
    input  logic rst_n,
    output logic cam_rst_n,
    output logic clk_div
);

    logic div_q;

    // Bring the reference-domain reset into the pixel-clock domain.
    clk_sync_bits #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_rst_sync (
        .clk   (cam_pclk),
        .rst_n (1'b1),
        .d     (rst_n),
        .q     (cam_rst_n)
    );

    // Toggle on every pixel clock rising edge, parked low in reset.
    always_ff @(posedge cam_pclk) begin
        if (!cam_rst_n) begin
            div_q <= 1'b0;
        end else begin
            div_q <= ~div_q;
        end
    end

    assign clk_div = div_q;

endmodule

// File: rtl/vsync_qualifier.sv
// Counts rising edges of the camera frame-sync line in the reference
// domain and raises a sticky switch request after NUM_VSYNC of them.
// Assumes vsync is asynchronous and each pulse lasts at least a few
// reference cycles in both levels.
module vsync_qualifier
    import clk_sw_pkg::*;
#(
    parameter int NUM_VSYNC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic vsync,
    output logic vs_lvl,
    output logic switch_req
);

    localparam int CW = cnt_width(NUM_VSYNC);
    localparam logic [CW-1:0] LAST = CW'(NUM_VSYNC - 1);

    logic          vs_prev_q;
    logic          vs_rise;
    logic [CW-1:0] edge_cnt_q;
    logic          req_q;

    // Synchronise the frame-sync level into the reference domain.
    clk_sync_bits #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_vs_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (vsync),
        .q     (vs_lvl)
    );

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            vs_prev_q <= 1'b0;
        end else begin
            vs_prev_q <= vs_lvl;
        end
    end

    assign vs_rise = vs_lvl & ~vs_prev_q;

    // Count qualified edges until the request is raised, then freeze.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            edge_cnt_q <= '0;
        end else if (vs_rise && !req_q) begin
            edge_cnt_q <= edge_cnt_q + 1'b1;
        end
    end

    // Raise the sticky request on the final qualifying edge.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (vs_rise && (edge_cnt_q == LAST)) begin
            req_q <= 1'b1;
        end
    end

    assign switch_req = req_q;

endmodule

// File: rtl/glitchless_clk_mux.sv
// Break-before-make 2:1 clock multiplexer. Each source enable is updated
// on the falling edge of its own clock and only rises after the other
// enable has been seen low through a synchroniser.
// Assumes want_alt is a reference-domain level and both clocks run.
module glitchless_clk_mux #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic ref_rst_n,
    input  logic alt_clk,
    input  logic alt_rst_n,
    input  logic want_alt,
    output logic clk_out,
    output logic ref_on,
    output logic alt_on,
    output logic alt_on_ref
);

    logic ref_on_q;
    logic alt_on_q;
    logic want_alt_a;
    logic ref_on_a;

    // Observe the alternate enable in the reference domain (assume on in reset).
    clk_sync_bits #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_alt_to_ref (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .d     (alt_on_q),
        .q     (alt_on_ref)
    );

    // Carry the selection request into the alternate domain.
    clk_sync_bits #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_req_to_alt (
        .clk   (alt_clk),
        .rst_n (alt_rst_n),
        .d     (want_alt),
        .q     (want_alt_a)
    );

    // Observe the reference enable in the alternate domain (assume on in reset).
    clk_sync_bits #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_ref_to_alt (
        .clk   (alt_clk),
        .rst_n (alt_rst_n),
        .d     (ref_on_q),
        .q     (ref_on_a)
    );

    // Reference enable: changes only while ref_clk is low.
    always_ff @(negedge ref_clk) begin
        if (!ref_rst_n) begin
            ref_on_q <= 1'b0;
        end else begin
            ref_on_q <= ~want_alt & ~alt_on_ref;
        end
    end

    // Alternate enable: changes only while alt_clk is low.
    always_ff @(negedge alt_clk) begin
        if (!alt_rst_n) begin
            alt_on_q <= 1'b0;
        end else begin
            alt_on_q <= want_alt_a & ~ref_on_a;
        end
    end

    assign clk_out = (ref_clk & ref_on_q) | (alt_clk & alt_on_q);
    assign ref_on  = ref_on_q;
    assign alt_on  = alt_on_q;

endmodule

// File: rtl/vsync_clk_switch.sv
// Top level: forwards the reference clock after reset and, once NUM_VSYNC
// frame-sync edges have been counted, hands clk_out over to cam_pclk / 2.
// The choice holds until reset. Assumes cam_pclk runs whenever rst_n is
// asserted, so that the camera-side enable is cleared.
module vsync_clk_switch
    import clk_sw_pkg::*;
#(
    parameter int NUM_VSYNC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic cam_pclk,
    input  logic vsync,
    output logic clk_out,
    output logic sel_cam
);

    logic     cam_rst_n;
    logic     cam_div;
    logic     vs_lvl;
    logic     switch_req;
    logic     ref_on;
    logic     cam_on;
    logic     cam_on_ref;
    clk_src_e src_q;

    pclk_div2 #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_div (
        .cam_pclk  (cam_pclk),
        .rst_n     (rst_n),
        .cam_rst_n (cam_rst_n),
        .clk_div   (cam_div)
    );

    vsync_qualifier #(
        .NUM_VSYNC   (NUM_VSYNC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_qual (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .vsync      (vsync),
        .vs_lvl     (vs_lvl),
        .switch_req (switch_req)
    );

    glitchless_clk_mux #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_mux (
        .ref_clk    (ref_clk),
        .ref_rst_n  (rst_n),
        .alt_clk    (cam_div),
        .alt_rst_n  (cam_rst_n),
        .want_alt   (switch_req),
        .clk_out    (clk_out),
        .ref_on     (ref_on),
        .alt_on     (cam_on),
        .alt_on_ref (cam_on_ref)
    );

    // Report the camera source only once the request stands and its enable is confirmed.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            src_q <= SRC_REF;
        end else begin
            src_q <= (switch_req && cam_on_ref) ? SRC_CAM : SRC_REF;
        end
    end

    assign sel_cam = (src_q == SRC_CAM);

endmodule

// File: rtl/vsync_clk_switch_chk.sv
// Property checker for vsync_clk_switch, attached by bind. Keeps its own
// count of synchronised frame-sync edges and of the hand-over latency.
module vsync_clk_switch_chk #(
    parameter int NUM_VSYNC = 4
) (
    input logic ref_clk,
    input logic rst_n,
    input logic vs_lvl,
    input logic req,
    input logic ref_on,
    input logic cam_on,
    input logic sel_cam
);

    localparam int LAT_MAX = 40;

    int   seen;
    int   req_age;
    logic vs_last;
    logic started;
    logic rst_last;

    // Independent tally of sync edges and of cycles since the request.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            seen    <= 0;
            vs_last <= 1'b0;
            req_age <= 0;
        end else begin
            vs_last <= vs_lvl;
            if (vs_lvl && !vs_last && seen < NUM_VSYNC) begin
                seen <= seen + 1;
            end
            if (req && req_age < LAT_MAX + 1) begin
                req_age <= req_age + 1;
            end
        end
    end

    // Remember the previous reset level for the reset-state check.
    always_ff @(posedge ref_clk) begin
        started  <= 1'b1;
        rst_last <= rst_n;
        if (started && !rst_last) begin
            assert_reset_status_R8: assert (!sel_cam)
                else $error("sel_cam set after a reset cycle");
        end
    end

    assert_break_before_make_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(ref_on && cam_on));

    assert_req_sticky_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        req |=> req);

    assert_no_early_switch_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        req |-> (seen >= NUM_VSYNC));

    assert_status_matches_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        sel_cam |-> (cam_on && !ref_on));

    assert_switch_latency_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (req_age >= LAT_MAX) |-> sel_cam);

endmodule

bind vsync_clk_switch vsync_clk_switch_chk #(
    .NUM_VSYNC (NUM_VSYNC)
) u_chk (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .vs_lvl  (vs_lvl),
    .req     (switch_req),
    .ref_on  (ref_on),
    .cam_on  (cam_on),
    .sel_cam (sel_cam)
);

// File: tb/vsync_clk_switch_tb.sv
`timescale 1ns/100ps
module vsync_clk_switch_tb;

    localparam int N = 4;

    logic ref_clk, rst_n, cam_pclk, vsync;
    logic clk_out, sel_cam;

    int checks = 0;
    int errors = 0;

    // reference model state
    int  edges = 0;
    bit  vprev = 0;
    int  since_rst = 0;
    int  rst_low = 0;
    int  since_req = 0;
    bit  sel_seen = 0;
    int  cycles = 0;
    int  cam_edges = 0;
    realtime last_rise = 0.0;
    realtime last_edge = 0.0;

    vsync_clk_switch #(.NUM_VSYNC(N)) u_dut (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .cam_pclk (cam_pclk),
        .vsync    (vsync),
        .clk_out  (clk_out),
        .sel_cam  (sel_cam)
    );

    initial begin
        ref_clk = 1'b0;
        forever #2 ref_clk = ~ref_clk;
    end

    initial begin
        cam_pclk = 1'b0;
        #0.7;
        forever #3.5 cam_pclk = ~cam_pclk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic frame(input int hi, input int lo);
        @(posedge cam_pclk);
        vsync = 1'b1;
        repeat (hi) @(posedge cam_pclk);
        vsync = 1'b0;
        repeat (lo) @(posedge cam_pclk);
    endtask

    task automatic do_reset();
        @(negedge ref_clk);
        rst_n = 1'b0;
        repeat (20) @(negedge ref_clk);
        rst_n = 1'b1;
    endtask

    // Behavioural model, updated and compared on every reference rising edge.
    always @(posedge ref_clk) begin
        cycles++;
        if (!rst_n) begin
            edges = 0; vprev = 0; since_rst = 0; since_req = 0; sel_seen = 0;
            rst_low++;
        end else begin
            rst_low = 0;
            if (vsync && !vprev) edges++;
            vprev = vsync;
            since_rst++;
            if (edges >= N) since_req++;
        end
        #1;
        if (!rst_n && rst_low >= 1)
            chk(sel_cam == 1'b0, "R8 status in reset", sel_cam, 0);
        if (rst_n && since_rst >= 4 && edges < N) begin
            chk(sel_cam == 1'b0, "R4 no early switch", sel_cam, 0);
            chk(clk_out == 1'b1, "R1 output high after ref rise", clk_out, 1);
        end
        if (rst_n && edges >= N && since_req > 40)
            chk(sel_cam == 1'b1, "R5 switch latency", sel_cam, 1);
        if (rst_n && sel_seen)
            chk(sel_cam == 1'b1, "R6 sticky selection", sel_cam, 1);
        if (rst_n && sel_cam) sel_seen = 1;
    end

    always @(negedge ref_clk) begin
        #1;
        if (rst_n && since_rst >= 4 && edges < N)
            chk(clk_out == 1'b0, "R1 output low after ref fall", clk_out, 0);
    end

    // Divided-clock period once the camera source is reported.
    always @(posedge clk_out) begin
        if (sel_cam) begin
            cam_edges++;
            if (cam_edges > 3)
                chk(($realtime - last_rise) > 13.9 && ($realtime - last_rise) < 14.1,
                    "R2 camera period x10", int'(($realtime - last_rise) * 10), 140);
        end else begin
            cam_edges = 0;
        end
        last_rise = $realtime;
    end

    // No runt phases on the output clock.
    always @(clk_out) begin
        if ($realtime > 50.0 && last_edge > 0.0)
            chk(($realtime - last_edge) > 1.9, "R7 minimum phase x10",
                int'(($realtime - last_edge) * 10), 20);
        last_edge = $realtime;
    end

    // Watchdog.
    always @(posedge ref_clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        vsync = 1'b0;
        repeat (20) @(negedge ref_clk);
        rst_n = 1'b1;
        repeat (10) @(negedge ref_clk);
        chk(sel_cam == 1'b0, "R1 reset state selects reference", sel_cam, 0);

        // Three edges, one of them a long pulse: must not switch.
        frame(10, 60);
        frame(200, 60);
        frame(10, 60);
        repeat (300) @(negedge ref_clk);
        chk(sel_cam == 1'b0, "R3 long pulse counted once", sel_cam, 0);
        chk(edges == 3, "R3 model edge tally", edges, 3);

        // Fourth edge: switch.
        frame(10, 60);
        repeat (60) @(negedge ref_clk);
        chk(sel_cam == 1'b1, "R5 switched after fourth edge", sel_cam, 1);
        repeat (40) @(negedge ref_clk);

        // More frames: remains on camera.
        frame(10, 40);
        frame(150, 40);
        frame(10, 40);
        chk(sel_cam == 1'b1, "R6 still camera after extra frames", sel_cam, 1);

        // Reset returns to reference.
        do_reset();
        repeat (10) @(negedge ref_clk);
        chk(sel_cam == 1'b0, "R6 reset returns to reference", sel_cam, 0);
        repeat (50) @(negedge ref_clk);

        // Partial count, reset, then three more: no switch.
        frame(10, 60);
        frame(10, 60);
        do_reset();
        repeat (10) @(negedge ref_clk);
        frame(10, 60);
        frame(10, 60);
        frame(10, 60);
        repeat (300) @(negedge ref_clk);
        chk(sel_cam == 1'b0, "R9 count cleared by reset", sel_cam, 0);
        frame(10, 60);
        repeat (60) @(negedge ref_clk);
        chk(sel_cam == 1'b1, "R9 switch after fresh count", sel_cam, 1);
        repeat (40) @(negedge ref_clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule